// File: doc/BRIEF.md
# DSSS Receive Acquisition Sequencer

This block is the control state machine for the receive front end of a direct-sequence spread-spectrum baseband. It takes the per-symbol carrier-sense strobes from the correlators (a coarse one, `cs1_i`, and a fine one, `cs2_i`), an energy-detect level, a start-of-frame-delimiter found pulse, header CRC16 verdict pulses and a one-microsecond tick. From these it produces a clear-channel indication, an acquired flag, a data-ready flag for the MAC side, a one-cycle SFD timeout pulse and the receive antenna select level.

While enabled, the sequencer searches for a valid carrier-sense pattern. Once it finds one, it declares acquisition and starts an SFD timer. When the SFD arrives, it raises data-ready either at once or only after the header CRC16 passes, depending on configuration. Data-ready stays high until end of packet. A configuration byte selects the acquisition rule, the timeout length, the data-ready release point, the CCA combination and the antenna level. That byte is captured only while the sequencer is idle or searching.

Configuration byte layout: bit 0 = CS2-only acquisition, bits 2:1 = SFD timeout code, bit 3 = data-ready at SFD, bits 5:4 = CCA mode, bit 6 = receive antenna level, bit 7 unused.

Top module: `dsss_rx_acq_seq`

## Requirements
- R1: While `rst_n` is low, all five outputs are low. After release the sequencer is idle.
- R2: `cca_o` is registered one cycle after its inputs, with the mode taken from the active configuration bits 5:4. Mode 00 gives `ed_i`. Mode 01 gives `cs1_i|cs2_i`. Mode 10 gives `ed_i&(cs1_i|cs2_i)`. Mode 11 gives `cs2_i`.
- R3: While searching with configuration bit 0 = 0, a strobe cycle with `cs2_i` that follows a `cs1_i` strobe or a `cs2_i` strobe, with no other strobe cycle between them, raises `acq_o` on the next cycle.
- R4: With bit 0 = 1, only a `cs2_i` strobe following a `cs2_i` strobe acquires, and a `cs1_i` strobe clears the partial pattern. A cycle with both strobes high counts as a `cs2_i` strobe in both modes.
- R5: After acquisition the sequencer counts `us_tick_i` pulses. The SFD timeout code in bits 2:1 selects 56, 64, 128 or 144 ticks for codes 00, 01, 10 and 11. If that many ticks pass with no SFD, `sfd_tmo_o` is high for exactly one cycle, `acq_o` drops at the same time, and searching resumes. An SFD in the expiring cycle wins.
- R6: With bit 3 = 1, `md_rdy_o` rises on the cycle after `sfd_i` is seen in the acquired state.
- R7: With bit 3 = 0, the sequencer waits after the SFD. `crc_ok_i` then raises `md_rdy_o`, and `crc_bad_i` (which has priority) returns it to searching with `md_rdy_o` never raised.
- R8: `md_rdy_o` stays high until `eop_i`. After `eop_i`, both `md_rdy_o` and `acq_o` drop and searching resumes.
- R9: `ant_sel_o` follows configuration bit 6 whenever the sequencer is not idle, and is low when idle.
- R10: The configuration byte is captured on every clock while idle or searching. Changes made while acquired, waiting or ready have no effect at the ports until searching resumes.
- R11: `rx_en_i` low sends the sequencer to idle on the next edge from any state. This drops `acq_o`, `md_rdy_o` and `ant_sel_o`, and suppresses a timeout pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en_i | input | 1 | Receive enable |
| cfg_i | input | 8 | Configuration byte |
| cs1_i | input | 1 | Coarse carrier-sense strobe |
| cs2_i | input | 1 | Fine carrier-sense strobe |
| ed_i | input | 1 | Energy-detect level |
| sfd_i | input | 1 | SFD found pulse |
| crc_ok_i | input | 1 | Header CRC16 passed pulse |
| crc_bad_i | input | 1 | Header CRC16 failed pulse |
| us_tick_i | input | 1 | One-microsecond tick |
| eop_i | input | 1 | End of packet pulse |
| cca_o | output | 1 | Clear-channel indication (registered) |
| acq_o | output | 1 | Acquisition declared |
| md_rdy_o | output | 1 | Data ready for the MAC |
| sfd_tmo_o | output | 1 | One-cycle SFD timeout pulse |
| ant_sel_o | output | 1 | Receive antenna select level |

## Verification
A partial carrier-sense pattern left stale, or one cleared wrongly, shows up at `acq_o` on the edge after the next `cs2_i` strobe. An acquisition is then missed or invented in that same cycle. A timer that is off by a count moves the `sfd_tmo_o` pulse by one tick and leaves `acq_o` high or low for one tick too long. A configuration register that is open when it should be frozen shows on `ant_sel_o` one cycle after `cfg_i` changes during a packet. The bench keeps a behavioural model in lock-step and compares all five outputs on every clock, so each of these faults is reported within one cycle of the first differing output.

// File: rtl/rxacq_pkg.sv
package rxacq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SEARCH = 3'd1,
      ST_WSFD   = 3'd2,
      ST_WCRC   = 3'd3,
      ST_READY  = 3'd4
   } rx_state_e;

   typedef enum logic [1:0] {
      PD_NONE = 2'd0,
      PD_CS1  = 2'd1,
      PD_CS2  = 2'd2
   } pend_e;

   typedef struct packed {
      logic       spare;
      logic       ant_hi;
      logic [1:0] cca_sel;
      logic       rdy_at_sfd;
      logic [1:0] tmo_sel;
      logic       cs2_only;
   } rx_cfg_t;

   localparam int CFG_W = $bits(rx_cfg_t);

endpackage

// File: rtl/rxacq_cca.sv
module rxacq_cca #(
   parameter bit REG_OUT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] sel,
   input  logic       ed,
   input  logic       cs1,
   input  logic       cs2,
   output logic       cca
);
   logic any_cs;
   logic cca_raw;

   assign any_cs = cs1 | cs2;

   always_comb begin
      unique case (sel)
         2'b00:   cca_raw = ed;
         2'b01:   cca_raw = any_cs;
         2'b10:   cca_raw = ed & any_cs;
         default: cca_raw = cs2;
      endcase
   end

   generate
      if (REG_OUT) begin : g_reg
         logic cca_q;
         always_ff @(posedge clk) begin
            if (!rst_n) cca_q <= 1'b0;
            else        cca_q <= cca_raw;
         end
         assign cca = cca_q;
      end else begin : g_comb
         assign cca = cca_raw;
      end
   endgenerate
endmodule

// File: rtl/rxacq_pattern.sv
module rxacq_pattern
   import rxacq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic cs2_only,
   input  logic cs1,
   input  logic cs2,
   output logic hit
);
   pend_e pend, pend_nx;

   always_comb begin
      hit     = 1'b0;
      pend_nx = pend;
      if (!active) begin
         pend_nx = PD_NONE;
      end else if (cs2) begin
         if (pend == PD_CS2 || (pend == PD_CS1 && !cs2_only)) begin
            hit     = 1'b1;
            pend_nx = PD_NONE;
         end else begin
            pend_nx = PD_CS2;
         end
      end else if (cs1) begin
         pend_nx = cs2_only ? PD_NONE : PD_CS1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pend <= PD_NONE;
      else        pend <= pend_nx;
   end
endmodule

// File: rtl/rxacq_sfd_timer.sv
module rxacq_sfd_timer #(
   parameter int LIM0 = 56,
   parameter int LIM1 = 64,
   parameter int LIM2 = 128,
   parameter int LIM3 = 144
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       tick,
   input  logic [1:0] sel,
   output logic       expire
);
   localparam int M01  = (LIM0 > LIM1) ? LIM0 : LIM1;
   localparam int M23  = (LIM2 > LIM3) ? LIM2 : LIM3;
   localparam int LMAX = (M01 > M23) ? M01 : M23;
   localparam int CW   = $clog2(LMAX + 1);

   generate
      if (LIM0 < 1 || LIM1 < 1 || LIM2 < 1 || LIM3 < 1) begin : g_bad_lim
         $error("rxacq_sfd_timer: every timeout limit must be at least one tick");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;

   always_comb begin
      unique case (sel)
         2'b00:   lim = CW'(LIM0);
         2'b01:   lim = CW'(LIM1);
         2'b10:   lim = CW'(LIM2);
         default: lim = CW'(LIM3);
      endcase
   end

   assign expire = run & tick & (cnt == lim - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) cnt <= '0;
      else if (tick)      cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/dsss_rx_acq_seq.sv
module dsss_rx_acq_seq
   import rxacq_pkg::*;
#(
   parameter int TMO_LIM0 = 56,
   parameter int TMO_LIM1 = 64,
   parameter int TMO_LIM2 = 128,
   parameter int TMO_LIM3 = 144,
   parameter bit CCA_REG  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_en_i,
   input  logic [7:0] cfg_i,
   input  logic       cs1_i,
   input  logic       cs2_i,
   input  logic       ed_i,
   input  logic       sfd_i,
   input  logic       crc_ok_i,
   input  logic       crc_bad_i,
   input  logic       us_tick_i,
   input  logic       eop_i,
   output logic       cca_o,
   output logic       acq_o,
   output logic       md_rdy_o,
   output logic       sfd_tmo_o,
   output logic       ant_sel_o
);
   generate
      if (CFG_W != 8) begin : g_bad_cfg
         $error("dsss_rx_acq_seq: configuration record must be one byte");
      end
   endgenerate

   rx_cfg_t   cfg_q;
   rx_state_e st, st_nx;
   logic      cfg_open;
   logic      hit;
   logic      expire;
   logic      tmo_q;

   assign cfg_open = (st == ST_IDLE) || (st == ST_SEARCH);

   always_ff @(posedge clk) begin
      if (!rst_n)        cfg_q <= '0;
      else if (cfg_open) cfg_q <= rx_cfg_t'(cfg_i);
   end

   rxacq_cca #(.REG_OUT(CCA_REG)) u_cca (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (cfg_q.cca_sel),
      .ed    (ed_i),
      .cs1   (cs1_i),
      .cs2   (cs2_i),
      .cca   (cca_o)
   );

   rxacq_pattern u_pat (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (st == ST_SEARCH),
      .cs2_only (cfg_q.cs2_only),
      .cs1      (cs1_i),
      .cs2      (cs2_i),
      .hit      (hit)
   );

   rxacq_sfd_timer #(
      .LIM0 (TMO_LIM0),
      .LIM1 (TMO_LIM1),
      .LIM2 (TMO_LIM2),
      .LIM3 (TMO_LIM3)
   ) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (st == ST_WSFD),
      .tick   (us_tick_i),
      .sel    (cfg_q.tmo_sel),
      .expire (expire)
   );

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE:   st_nx = ST_SEARCH;
         ST_SEARCH: if (hit) st_nx = ST_WSFD;
         ST_WSFD: begin
            if (sfd_i)       st_nx = cfg_q.rdy_at_sfd ? ST_READY : ST_WCRC;
            else if (expire) st_nx = ST_SEARCH;
         end
         ST_WCRC: begin
            if (crc_bad_i)     st_nx = ST_SEARCH;
            else if (crc_ok_i) st_nx = ST_READY;
         end
         ST_READY:  if (eop_i) st_nx = ST_SEARCH;
         default:   st_nx = ST_IDLE;
      endcase
      if (!rx_en_i) st_nx = ST_IDLE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         tmo_q <= 1'b0;
      end else begin
         st    <= st_nx;
         tmo_q <= (st == ST_WSFD) && rx_en_i && !sfd_i && expire;
      end
   end

   assign acq_o     = (st == ST_WSFD) || (st == ST_WCRC) || (st == ST_READY);
   assign md_rdy_o  = (st == ST_READY);
   assign sfd_tmo_o = tmo_q;
   assign ant_sel_o = (st != ST_IDLE) && cfg_q.ant_hi;
endmodule

// File: rtl/rxacq_chk.sv
module rxacq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rx_en_i,
   input logic       eop_i,
   input logic       acq_o,
   input logic       md_rdy_o,
   input logic       sfd_tmo_o,
   input logic       ant_sel_o,
   input logic [7:0] cfg_q
);
   // R6 / R7: data-ready is only ever seen inside an acquired packet
   p_rdy_needs_acq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      md_rdy_o |-> acq_o);

   p_tmo_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sfd_tmo_o |=> !sfd_tmo_o);

   p_tmo_leaves_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sfd_tmo_o |-> !acq_o);

   p_rdy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (md_rdy_o && rx_en_i && !eop_i) |=> md_rdy_o);

   p_disable_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en_i |=> (!acq_o && !md_rdy_o && !sfd_tmo_o));

   p_ant_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en_i |=> !ant_sel_o);

   p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      acq_o |=> $stable(cfg_q));
endmodule

bind dsss_rx_acq_seq rxacq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_en_i   (rx_en_i),
   .eop_i     (eop_i),
   .acq_o     (acq_o),
   .md_rdy_o  (md_rdy_o),
   .sfd_tmo_o (sfd_tmo_o),
   .ant_sel_o (ant_sel_o),
   .cfg_q     (cfg_q)
);

// File: tb/tb_dsss_rx_acq_seq.sv
module tb_dsss_rx_acq_seq;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_n, rx_en, cs1, cs2, ed, sfd, ok, bad, tick, eop;
   logic [7:0] cfg;
   logic       cca, acq, rdy, tmo, ant;
   int         checks = 0;
   int         fails  = 0;
   bit         done   = 1'b0;

   dsss_rx_acq_seq dut (
      .clk(clk), .rst_n(rst_n), .rx_en_i(rx_en), .cfg_i(cfg),
      .cs1_i(cs1), .cs2_i(cs2), .ed_i(ed), .sfd_i(sfd),
      .crc_ok_i(ok), .crc_bad_i(bad), .us_tick_i(tick), .eop_i(eop),
      .cca_o(cca), .acq_o(acq), .md_rdy_o(rdy), .sfd_tmo_o(tmo), .ant_sel_o(ant)
   );

   // reference model state: 0 idle, 1 search, 2 wait SFD, 3 wait CRC, 4 ready
   int         m_st, m_pend, m_cnt;
   logic [7:0] m_cfg;
   logic       m_cca, m_tmo;

   function automatic logic [7:0] mk(bit strict, bit [1:0] t, bit rs, bit [1:0] cm, bit an);
      return {1'b0, an, cm, rs, t, strict};
   endfunction

   function automatic int lim_of(logic [1:0] c);
      case (c)
         2'd0:    return 56;
         2'd1:    return 64;
         2'd2:    return 128;
         default: return 144;
      endcase
   endfunction

   task automatic chk(logic got, logic exp, string tag);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%0b exp=%0b at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic chk_int(int got, int exp, string tag);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_pend = 0; m_cnt = 0; m_cfg = 8'h00; m_cca = 1'b0; m_tmo = 1'b0;
      end else begin : upd
         int   nst;
         logic t;
         logic cc;
         nst = m_st;
         t   = 1'b0;
         case (m_cfg[5:4])
            2'd0:    cc = ed;
            2'd1:    cc = cs1 | cs2;
            2'd2:    cc = ed & (cs1 | cs2);
            default: cc = cs2;
         endcase
         if (m_st == 1) begin
            if (cs2) begin
               if (m_pend == 2 || (m_pend == 1 && !m_cfg[0])) begin
                  nst = 2; m_pend = 0;
               end else m_pend = 2;
            end else if (cs1) m_pend = m_cfg[0] ? 0 : 1;
         end else m_pend = 0;
         if (m_st == 2) begin
            if (tick) m_cnt++;
            if (sfd) nst = m_cfg[3] ? 4 : 3;
            else if (tick && m_cnt == lim_of(m_cfg[2:1])) begin
               nst = 1; t = 1'b1;
            end
         end else m_cnt = 0;
         case (m_st)
            0: nst = 1;
            3: if (bad) nst = 1; else if (ok) nst = 4;
            4: if (eop) nst = 1;
            default: ;
         endcase
         if (!rx_en) begin
            nst = 0; t = 1'b0;
         end
         if (m_st <= 1) m_cfg = cfg;
         m_st  = nst;
         m_tmo = t;
         m_cca = cc;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(cca, m_cca, "R2 cca vs model");
         chk(acq, m_st >= 2, "R3/R4 acq vs model");
         chk(rdy, m_st == 4, "R6/R7/R8 md_rdy vs model");
         chk(tmo, m_tmo, "R5 timeout vs model");
         chk(ant, (m_st != 0) && m_cfg[6], "R9 antenna vs model");
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic p_cs1;  cs1 = 1; @(negedge clk); cs1 = 0; endtask
   task automatic p_cs2;  cs2 = 1; @(negedge clk); cs2 = 0; endtask
   task automatic p_both; cs1 = 1; cs2 = 1; @(negedge clk); cs1 = 0; cs2 = 0; endtask
   task automatic p_sfd;  sfd = 1; @(negedge clk); sfd = 0; endtask
   task automatic p_ok;   ok  = 1; @(negedge clk); ok  = 0; endtask
   task automatic p_bad;  bad = 1; @(negedge clk); bad = 0; endtask
   task automatic p_eop;  eop = 1; @(negedge clk); eop = 0; endtask

   // acquires with a CS2 pair, then counts cycles of continuous ticks to the timeout pulse
   task automatic time_out(logic [1:0] code);
      int n;
      cfg = mk(1'b0, code, 1'b0, 2'd0, 1'b0);
      cyc(2);
      p_cs2; p_cs2;
      chk(acq, 1'b1, "R3 cs2 pair acquires before timeout run");
      tick = 1;
      n = 0;
      while (!tmo && n < 400) begin
         @(negedge clk);
         n++;
      end
      tick = 0;
      chk_int(n, lim_of(code), "R5 ticks until timeout");
      chk(acq, 1'b0, "R5 acq dropped with timeout");
      @(negedge clk);
      chk(tmo, 1'b0, "R5 timeout lasts one cycle");
   endtask

   initial begin
      rst_n = 0; rx_en = 0; cs1 = 0; cs2 = 0; ed = 0; sfd = 0;
      ok = 0; bad = 0; tick = 0; eop = 0; cfg = 8'h00;
      cyc(3);
      chk(acq, 1'b0, "R1 reset acq");
      chk(rdy, 1'b0, "R1 reset md_rdy");
      chk(tmo, 1'b0, "R1 reset timeout");
      chk(cca, 1'b0, "R1 reset cca");
      chk(ant, 1'b0, "R1 reset antenna");
      rst_n = 1;

      // loose rule, CS1 then CS2, 56-tick timeout
      cfg = mk(1'b0, 2'd0, 1'b0, 2'd0, 1'b1);
      rx_en = 1; ed = 1;
      cyc(3);
      chk(ant, 1'b1, "R9 antenna high while searching");
      chk(cca, 1'b1, "R2 mode 00 follows energy detect");
      p_cs1; cyc(2); p_cs2;
      chk(acq, 1'b1, "R3 cs1 then cs2 acquires");
      ed = 0;
      time_out(2'd0);

      // strict rule
      cfg = mk(1'b1, 2'd1, 1'b1, 2'd3, 1'b0);
      cyc(2);
      p_cs1; p_cs2;
      chk(acq, 1'b0, "R4 cs1 then cs2 ignored when strict");
      p_cs1;
      p_cs2; p_cs1; p_cs2;
      chk(acq, 1'b0, "R4 cs1 between cs2 strobes clears pair");
      cs2 = 1; @(negedge clk);
      chk(cca, 1'b1, "R2 mode 11 follows cs2");
      cs2 = 0;
      chk(acq, 1'b1, "R4 two cs2 strobes acquire");
      p_sfd;
      chk(rdy, 1'b1, "R6 md_rdy right after SFD");
      cfg = mk(1'b1, 2'd1, 1'b1, 2'd3, 1'b1);
      cyc(3);
      chk(ant, 1'b0, "R10 cfg change ignored while ready");
      chk(rdy, 1'b1, "R8 md_rdy held");
      p_eop;
      chk(rdy, 1'b0, "R8 eop clears md_rdy");
      chk(acq, 1'b0, "R8 eop returns to search");
      cyc(1);
      chk(ant, 1'b1, "R10 cfg applied once searching");

      // loose rule, data-ready after CRC
      cfg = mk(1'b0, 2'd3, 1'b0, 2'd2, 1'b1);
      cyc(2);
      p_cs2; p_cs2;
      chk(acq, 1'b1, "R3 cs2 pair acquires");
      p_sfd;
      chk(rdy, 1'b0, "R7 waits for CRC after SFD");
      p_bad;
      chk(acq, 1'b0, "R7 crc fail returns to search");
      chk(rdy, 1'b0, "R7 crc fail never raises md_rdy");
      p_cs1; p_cs2; p_sfd; p_ok;
      chk(rdy, 1'b1, "R7 crc pass raises md_rdy");
      rx_en = 0;
      cyc(1);
      chk(acq, 1'b0, "R11 disable drops acq");
      chk(rdy, 1'b0, "R11 disable drops md_rdy");
      chk(ant, 1'b0, "R11 idle antenna low");
      rx_en = 1;
      cyc(2);

      // simultaneous strobes count as cs2 in strict mode
      cfg = mk(1'b1, 2'd0, 1'b0, 2'd1, 1'b0);
      cyc(2);
      p_both; p_both;
      chk(acq, 1'b1, "R4 simultaneous strobes act as cs2");
      rx_en = 0; cyc(1); rx_en = 1; cyc(1);

      time_out(2'd1);
      time_out(2'd2);
      time_out(2'd3);

      // random traffic against the model
      for (int i = 0; i < 3000; i++) begin
         if (i % 60 == 0) cfg = 8'($urandom);
         rx_en = ($urandom % 64) != 0;
         ed    = $urandom % 2;
         cs1   = ($urandom % 4) == 0;
         cs2   = ($urandom % 4) == 0;
         sfd   = ($urandom % 24) == 0;
         ok    = ($urandom % 6) == 0;
         bad   = ($urandom % 10) == 0;
         eop   = ($urandom % 20) == 0;
         tick  = $urandom % 2;
         @(negedge clk);
      end
      cs1 = 0; cs2 = 0; sfd = 0; ok = 0; bad = 0; eop = 0; tick = 0;
      cyc(2);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog run unfinished got=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule